// File: doc/BRIEF.md
# Two-Road Crossing Signal Controller

This block runs the signals at a junction where a main road crosses a side road. Each road has three lamp outputs: red, yellow and green. A Moore state machine steps through four phases in a fixed loop. It advances on a one-second enable pulse that is made from the system clock. Because the lamps are a pure function of the phase, a road is never given green while the other road is anything but red.

For each road the block also keeps a count of the seconds left before that road's lamp changes. The count is converted to two decimal digits and driven onto a two-digit seven-segment group. The two digits share segment lines and take turns under a scan select that alternates at a few hundred hertz. While a road waits at red, its count covers the whole green and yellow time of the other road. A driver therefore always sees the true wait.

Both rates are single-cycle enables in the system clock domain, not derived clocks. The divide ratios are parameters. The block has no input other than clock and reset.

Top module: `tl_crossing_ctrl`

## Requirements
- R1: The phases run in the loop 0,1,2,3,0. Phase 0 is main green with side red. Phase 1 is main yellow with side red. Phase 2 is side green with main red. Phase 3 is side yellow with main red. At no time are both red outputs low.
- R2: Exactly one of the three lamp outputs of each road is 1 in every cycle, including during reset. Lamp outputs change in the same cycle as the phase.
- R3: A one-second tick pulses for one cycle every TICK_DIV cycles. The first pulse is high in the TICK_DIV-th cycle after reset is released. On the edge after a tick, both road counts and the phase counter drop by one unless a phase change is due. Without a tick they hold.
- R4: A phase change happens on the edge after a tick that finds the phase counter at zero. A green phase therefore spans GREEN_HOLD+1 ticks (25 by default) and a yellow phase spans YELLOW_HOLD+1 ticks (5).
- R5: A synchronous active-high reset puts the controller in phase 0 with a main count of 24 and a side count of 29. It clears both rate counters. Segment and digit-enable outputs are 0 while in reset.
- R6: On entry to either yellow phase, both road counts load YELLOW_HOLD (4).
- R7: On entry to a green phase, the road turning green loads GREEN_HOLD (24). The road turning red loads GREEN_HOLD+YELLOW_HOLD+1 (29).
- R8: Each count is shown in decimal, converted by shift-and-add-3. The scan select toggles once per SCAN_DIV cycles. Digit enable is one-hot and active-high: bit 0 lights the ones digit and bit 1 lights the tens digit. Segment and enable outputs are registered, so they show the count and select of the previous cycle.
- R9: The segment word is 7 bits, active-high, with segment a at bit 6 down to segment g at bit 0. The digits 0 to 9 encode as 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F, 7B (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| main_red | output | 1 | Main road red lamp |
| main_yellow | output | 1 | Main road yellow lamp |
| main_green | output | 1 | Main road green lamp |
| side_red | output | 1 | Side road red lamp |
| side_yellow | output | 1 | Side road yellow lamp |
| side_green | output | 1 | Side road green lamp |
| main_seg | output | 7 | Main road segments, a at bit 6 to g at bit 0 |
| main_dig_en | output | 2 | Main road digit enable, bit 0 ones, bit 1 tens |
| side_seg | output | 7 | Side road segments, a at bit 6 to g at bit 0 |
| side_dig_en | output | 2 | Side road digit enable, bit 0 ones, bit 1 tens |

## Verification
The properties assume that reset is sampled on a clock edge and held for at least one cycle, since the only input is that synchronous reset. They also assume the hold parameters keep every count below 100, so two decimal digits are enough. The stimulus uses short divide ratios (a tick every 20 cycles, a scan toggle every 3) so that several full loops of the phase cycle fit in the run. It releases reset at time zero and applies it a second time in the middle of a green phase. After that second reset the tick spacing and reload values must start again from the same state as at power-up.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [1:0] {
    PH_MAIN_GO   = 2'd0,
    PH_MAIN_WARN = 2'd1,
    PH_SIDE_GO   = 2'd2,
    PH_SIDE_WARN = 2'd3
  } phase_e;

  typedef struct packed {
    logic red;
    logic yellow;
    logic green;
  } lamp_t;

  localparam lamp_t LAMP_RED    = '{red: 1'b1, yellow: 1'b0, green: 1'b0};
  localparam lamp_t LAMP_YELLOW = '{red: 1'b0, yellow: 1'b1, green: 1'b0};
  localparam lamp_t LAMP_GREEN  = '{red: 1'b0, yellow: 1'b0, green: 1'b1};

  function automatic lamp_t main_lamp(input phase_e p);
    case (p)
      PH_MAIN_GO:   main_lamp = LAMP_GREEN;
      PH_MAIN_WARN: main_lamp = LAMP_YELLOW;
      default:      main_lamp = LAMP_RED;
    endcase
  endfunction

  function automatic lamp_t side_lamp(input phase_e p);
    case (p)
      PH_SIDE_GO:   side_lamp = LAMP_GREEN;
      PH_SIDE_WARN: side_lamp = LAMP_YELLOW;
      default:      side_lamp = LAMP_RED;
    endcase
  endfunction

  // Active-high segments, bit 6 = a ... bit 0 = g
  function automatic logic [6:0] seg_encode(input logic [3:0] d);
    case (d)
      4'd0:    seg_encode = 7'h7E;
      4'd1:    seg_encode = 7'h30;
      4'd2:    seg_encode = 7'h6D;
      4'd3:    seg_encode = 7'h79;
      4'd4:    seg_encode = 7'h33;
      4'd5:    seg_encode = 7'h5B;
      4'd6:    seg_encode = 7'h5F;
      4'd7:    seg_encode = 7'h70;
      4'd8:    seg_encode = 7'h7F;
      4'd9:    seg_encode = 7'h7B;
      default: seg_encode = 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/tl_pulse_gen.sv
// Single-cycle enable every DIV clocks; first pulse DIV cycles after reset.
module tl_pulse_gen #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  output logic pulse
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      pulse <= 1'b0;
    end
  end

endmodule

// File: rtl/tl_phase_fsm.sv
// Four-phase Moore controller with per-road remaining-time counters.
module tl_phase_fsm
  import tl_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int GREEN_HOLD  = 24,
  parameter int YELLOW_HOLD = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output lamp_t            lamp_main,
  output lamp_t            lamp_side,
  output logic [CNT_W-1:0] main_left,
  output logic [CNT_W-1:0] side_left,
  output logic [CNT_W-1:0] hold_left
);

  localparam int RED_HOLD = GREEN_HOLD + YELLOW_HOLD + 1;
  localparam logic [CNT_W-1:0] LD_GREEN  = CNT_W'(GREEN_HOLD);
  localparam logic [CNT_W-1:0] LD_YELLOW = CNT_W'(YELLOW_HOLD);
  localparam logic [CNT_W-1:0] LD_RED    = CNT_W'(RED_HOLD);

  phase_e           phase;
  phase_e           phase_nxt;
  logic [CNT_W-1:0] ld_hold;
  logic [CNT_W-1:0] ld_main;
  logic [CNT_W-1:0] ld_side;
  logic             advance;

  assign advance = tick && (hold_left == '0);

  always_comb begin
    case (phase)
      PH_MAIN_GO:   phase_nxt = PH_MAIN_WARN;
      PH_MAIN_WARN: phase_nxt = PH_SIDE_GO;
      PH_SIDE_GO:   phase_nxt = PH_SIDE_WARN;
      default:      phase_nxt = PH_MAIN_GO;
    endcase
  end

  // Reload values chosen by the phase being entered
  always_comb begin
    case (phase_nxt)
      PH_MAIN_GO: begin
        ld_hold = LD_GREEN;
        ld_main = LD_GREEN;
        ld_side = LD_RED;
      end
      PH_SIDE_GO: begin
        ld_hold = LD_GREEN;
        ld_main = LD_RED;
        ld_side = LD_GREEN;
      end
      default: begin
        ld_hold = LD_YELLOW;
        ld_main = LD_YELLOW;
        ld_side = LD_YELLOW;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_MAIN_GO;
      hold_left <= LD_GREEN;
      main_left <= LD_GREEN;
      side_left <= LD_RED;
      lamp_main <= main_lamp(PH_MAIN_GO);
      lamp_side <= side_lamp(PH_MAIN_GO);
    end else if (advance) begin
      phase     <= phase_nxt;
      hold_left <= ld_hold;
      main_left <= ld_main;
      side_left <= ld_side;
      lamp_main <= main_lamp(phase_nxt);
      lamp_side <= side_lamp(phase_nxt);
    end else if (tick) begin
      hold_left <= hold_left - 1'b1;
      main_left <= main_left - 1'b1;
      side_left <= side_left - 1'b1;
    end
  end

endmodule

// File: rtl/tl_bin2bcd.sv
// Combinational shift-and-add-3 binary to BCD conversion.
module tl_bin2bcd #(
  parameter int W      = 8,
  parameter int DIGITS = 2
) (
  input  logic [W-1:0]          bin,
  output logic [4*DIGITS-1:0]   bcd
);

  localparam int ZW = 4 * DIGITS + W;

  logic [ZW-1:0] z;

  always_comb begin
    z = {{(4*DIGITS){1'b0}}, bin};
    for (int s = 0; s < W; s++) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (z[W + 4*d +: 4] > 4'd4) begin
          z[W + 4*d +: 4] = z[W + 4*d +: 4] + 4'd3;
        end
      end
      z = z << 1;
    end
    bcd = z[W +: 4*DIGITS];
  end

endmodule

// File: rtl/tl_digit_scan.sv
// Two-digit multiplexed display driver with registered outputs.
module tl_digit_scan
  import tl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic [CNT_W-1:0] value,
  output logic [6:0]       seg,
  output logic [1:0]       dig_en
);

  logic [7:0] bcd;
  logic [3:0] digit;

  tl_bin2bcd #(
    .W      (CNT_W),
    .DIGITS (2)
  ) u_bcd (
    .bin (value),
    .bcd (bcd)
  );

  assign digit = sel ? bcd[7:4] : bcd[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      seg    <= '0;
      dig_en <= '0;
    end else begin
      seg    <= seg_encode(digit);
      dig_en <= sel ? 2'b10 : 2'b01;
    end
  end

endmodule

// File: rtl/tl_crossing_ctrl.sv
module tl_crossing_ctrl
  import tl_pkg::*;
#(
  parameter int TICK_DIV    = 100_000_000,
  parameter int SCAN_DIV    = 500_000,
  parameter int CNT_W       = 8,
  parameter int GREEN_HOLD  = 24,
  parameter int YELLOW_HOLD = 4
) (
  input  logic       clk,
  input  logic       rst,
  output logic       main_red,
  output logic       main_yellow,
  output logic       main_green,
  output logic       side_red,
  output logic       side_yellow,
  output logic       side_green,
  output logic [6:0] main_seg,
  output logic [1:0] main_dig_en,
  output logic [6:0] side_seg,
  output logic [1:0] side_dig_en
);

  localparam int ROADS = 2;

  logic             tick_sec;
  logic             tick_scan;
  logic             scan_sel;
  lamp_t            lamp_main;
  lamp_t            lamp_side;
  logic [CNT_W-1:0] main_left;
  logic [CNT_W-1:0] side_left;
  logic [CNT_W-1:0] hold_left;
  logic [CNT_W-1:0] road_left [ROADS];
  logic [6:0]       road_seg  [ROADS];
  logic [1:0]       road_en   [ROADS];

  tl_pulse_gen #(.DIV(TICK_DIV)) u_sec (
    .clk   (clk),
    .rst   (rst),
    .pulse (tick_sec)
  );

  tl_pulse_gen #(.DIV(SCAN_DIV)) u_scan_rate (
    .clk   (clk),
    .rst   (rst),
    .pulse (tick_scan)
  );

  always_ff @(posedge clk) begin
    if (rst)            scan_sel <= 1'b0;
    else if (tick_scan) scan_sel <= ~scan_sel;
  end

  tl_phase_fsm #(
    .CNT_W       (CNT_W),
    .GREEN_HOLD  (GREEN_HOLD),
    .YELLOW_HOLD (YELLOW_HOLD)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_sec),
    .lamp_main (lamp_main),
    .lamp_side (lamp_side),
    .main_left (main_left),
    .side_left (side_left),
    .hold_left (hold_left)
  );

  assign road_left[0] = main_left;
  assign road_left[1] = side_left;

  for (genvar g = 0; g < ROADS; g++) begin : g_road
    tl_digit_scan #(.CNT_W(CNT_W)) u_disp (
      .clk    (clk),
      .rst    (rst),
      .sel    (scan_sel),
      .value  (road_left[g]),
      .seg    (road_seg[g]),
      .dig_en (road_en[g])
    );
  end

  assign main_red    = lamp_main.red;
  assign main_yellow = lamp_main.yellow;
  assign main_green  = lamp_main.green;
  assign side_red    = lamp_side.red;
  assign side_yellow = lamp_side.yellow;
  assign side_green  = lamp_side.green;
  assign main_seg    = road_seg[0];
  assign main_dig_en = road_en[0];
  assign side_seg    = road_seg[1];
  assign side_dig_en = road_en[1];

endmodule

// File: rtl/tl_crossing_chk.sv
module tl_crossing_chk #(
  parameter int CNT_W       = 8,
  parameter int GREEN_HOLD  = 24,
  parameter int YELLOW_HOLD = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             main_red,
  input logic             main_yellow,
  input logic             main_green,
  input logic             side_red,
  input logic             side_yellow,
  input logic             side_green,
  input logic [CNT_W-1:0] main_left,
  input logic [CNT_W-1:0] side_left,
  input logic [CNT_W-1:0] hold_left,
  input logic [1:0]       main_dig_en,
  input logic [1:0]       side_dig_en
);

  localparam logic [CNT_W-1:0] C_GREEN  = CNT_W'(GREEN_HOLD);
  localparam logic [CNT_W-1:0] C_YELLOW = CNT_W'(YELLOW_HOLD);
  localparam logic [CNT_W-1:0] C_RED    = CNT_W'(GREEN_HOLD + YELLOW_HOLD + 1);

  AST_ROAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    main_red || side_red); // R1

  AST_MAIN_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
    $onehot({main_red, main_yellow, main_green})); // R2

  AST_SIDE_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
    $onehot({side_red, side_yellow, side_green})); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && hold_left != '0) |=> (main_left == $past(main_left) - 1'b1)); // R3

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(main_left) && $stable(side_left))); // R3

  AST_PHASE_END: assert property (@(posedge clk) disable iff (rst)
    (tick && hold_left == '0) |=> !$stable({main_red, main_yellow, main_green, side_red, side_yellow, side_green})); // R4

  AST_YELLOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    ($rose(main_yellow) || $rose(side_yellow)) |-> (main_left == C_YELLOW && side_left == C_YELLOW)); // R6

  AST_GREEN_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(side_green) |-> (side_left == C_GREEN && main_left == C_RED)); // R7

  AST_SCAN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(main_dig_en) && (main_dig_en == side_dig_en)); // R8

endmodule

bind tl_crossing_ctrl tl_crossing_chk #(
  .CNT_W       (CNT_W),
  .GREEN_HOLD  (GREEN_HOLD),
  .YELLOW_HOLD (YELLOW_HOLD)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick_sec),
  .main_red    (main_red),
  .main_yellow (main_yellow),
  .main_green  (main_green),
  .side_red    (side_red),
  .side_yellow (side_yellow),
  .side_green  (side_green),
  .main_left   (main_left),
  .side_left   (side_left),
  .hold_left   (hold_left),
  .main_dig_en (main_dig_en),
  .side_dig_en (side_dig_en)
);

// File: tb/tl_crossing_ctrl_tb.sv
`timescale 1ns/1ps
module tl_crossing_ctrl_tb;

  localparam int TDIV = 20;
  localparam int SDIV = 3;
  localparam int GH   = 24;
  localparam int YH   = 4;
  localparam int RH   = GH + YH + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       main_red, main_yellow, main_green;
  logic       side_red, side_yellow, side_green;
  logic [6:0] main_seg, side_seg;
  logic [1:0] main_dig_en, side_dig_en;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tl_crossing_ctrl #(
    .TICK_DIV    (TDIV),
    .SCAN_DIV    (SDIV),
    .CNT_W       (8),
    .GREEN_HOLD  (GH),
    .YELLOW_HOLD (YH)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .main_red    (main_red),
    .main_yellow (main_yellow),
    .main_green  (main_green),
    .side_red    (side_red),
    .side_yellow (side_yellow),
    .side_green  (side_green),
    .main_seg    (main_seg),
    .main_dig_en (main_dig_en),
    .side_seg    (side_seg),
    .side_dig_en (side_dig_en)
  );

  // ---------------- reference model ----------------
  int    m_tcnt, m_tick, m_scnt, m_stick, m_sel;
  int    m_phase, m_hold, m_main, m_side;
  int    m_seg_main, m_seg_side, m_en;
  string m_tag;

  function automatic int seg_of(input int d);
    int t[10] = '{'h7E, 'h30, 'h6D, 'h79, 'h33, 'h5B, 'h5F, 'h70, 'h7F, 'h7B};
    return t[d];
  endfunction

  // bits {red,yellow,green}
  function automatic int lamps_of(input int ph);
    int mn, sd;
    mn = (ph == 0) ? 1 : (ph == 1) ? 2 : 4;
    sd = (ph == 2) ? 1 : (ph == 3) ? 2 : 4;
    return (mn << 3) | sd;
  endfunction

  task automatic model_edge(input bit r);
    if (r) begin
      m_tcnt = 0; m_tick = 0; m_scnt = 0; m_stick = 0; m_sel = 0;
      m_phase = 0; m_hold = GH; m_main = GH; m_side = RH;
      m_seg_main = 0; m_seg_side = 0; m_en = 0;
      m_tag = "R5";
      return;
    end
    // registered display from previous-cycle count and select
    m_seg_main = seg_of(m_sel ? m_main / 10 : m_main % 10);
    m_seg_side = seg_of(m_sel ? m_side / 10 : m_side % 10);
    m_en = m_sel ? 2 : 1;
    if (m_stick != 0) m_sel = 1 - m_sel;
    if (m_tick != 0) begin
      if (m_hold == 0) begin
        m_phase = (m_phase + 1) % 4;
        if (m_phase == 0)      begin m_hold = GH; m_main = GH; m_side = RH; m_tag = "R7"; end
        else if (m_phase == 2) begin m_hold = GH; m_main = RH; m_side = GH; m_tag = "R7"; end
        else                   begin m_hold = YH; m_main = YH; m_side = YH; m_tag = "R6"; end
      end else begin
        m_hold--; m_main--; m_side--;
        m_tag = "R3";
      end
    end
    if (m_tcnt == TDIV - 1) begin m_tcnt = 0; m_tick = 1; end
    else begin m_tcnt++; m_tick = 0; end
    if (m_scnt == SDIV - 1) begin m_scnt = 0; m_stick = 1; end
    else begin m_scnt++; m_stick = 0; end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  int prev_lamps = -1;

  task automatic compare();
    int lamps;
    string ltag;
    lamps = {26'd0, main_red, main_yellow, main_green, side_red, side_yellow, side_green};
    ltag = (prev_lamps != lamps_of(m_phase) && prev_lamps != -1) ? "R4/R1" : "R1";
    chk(ltag, lamps, lamps_of(m_phase));
    prev_lamps = lamps_of(m_phase);
    chk("R2", ($countones({main_red, main_yellow, main_green}) == 1 &&
               $countones({side_red, side_yellow, side_green}) == 1) ? 1 : 0, 1);
    chk({m_tag, "/R9 main"}, int'(main_seg), m_seg_main);
    chk({m_tag, "/R9 side"}, int'(side_seg), m_seg_side);
    chk("R8", int'({main_dig_en, side_dig_en}), (m_en << 2) | m_en);
  endtask

  task automatic run(input int n, input bit r);
    for (int i = 0; i < n; i++) begin
      rst = r;
      @(posedge clk);
      model_edge(r);
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    @(negedge clk);
    run(3, 1'b1);      // R5 reset state
    run(2600, 1'b0);   // two full loops: R1 R3 R4 R6 R7 R8 R9
    run(2, 1'b1);      // reset mid green: R5
    run(1400, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule